// File: doc/BRIEF.md
# Peripheral Bus Master Sequencer

This block is the master side of a simple two-phase peripheral bus with no wait states. A local client presents an address, a write flag, write data and a request. The sequencer accepts the request with a one-cycle acknowledge and runs one bus transfer. The transfer has a setup cycle, in which a select line and the address become valid, and then an access cycle, in which the enable strobe is raised. After the access cycle the block pulses a completion flag. For reads, the completion flag comes with the data that was sampled from the slave.

One select line is driven for each peripheral region, and they are decoded from the upper address bits. An address outside every region still runs the full two-cycle sequence, but with all selects low, and a read from it returns zero. A request presented during the access cycle is taken at once, so transfers can follow each other with no idle cycle between them. In that case the select stays high when both transfers go to the same region. Between transfers the address and write flag keep their last values, so that those wires do not toggle and waste power.

Top module: `pbus_master_seq`

## Requirements
- R1: While synchronous active-high `rst` is high, at the next edge the block enters idle with `bus_sel`, `bus_enable`, `done`, `bus_addr`, `bus_wdata`, `bus_write` and `rd_data` all zero, and `cmd_ack` is held low during reset.
- R2: `cmd_ack` is high exactly when `cmd_req` is high and the sequencer is in the idle cycle or the access cycle. It is never high in the setup cycle, and a request is accepted at the edge where `cmd_ack` is high.
- R3: In the cycle after acceptance (setup), `bus_addr`, `bus_write` and `bus_wdata` equal the accepted command and `bus_enable` is 0.
- R4: Setup lasts exactly one cycle and is always followed by one access cycle with `bus_enable`=1, in which address, write flag, write data and selects are unchanged from setup.
- R5: After an access cycle with no accepted request, the bus returns to idle. In idle `bus_sel` is all zero and `bus_enable` is 0, and `bus_addr` and `bus_write` keep their last values until the next accepted request.
- R6: A request accepted in the access cycle starts the next setup immediately, with `bus_enable` low for that cycle. If the new address decodes to the same region, its select bit stays high without a gap.
- R7: The region is decoded from address bits [13:12], which select `bus_sel` bit 0 to 3. Any address with bits [15:14] nonzero matches no region, and `bus_sel` stays all zero through its transfer. At most one select bit is ever high.
- R8: `done` is high for exactly the one cycle after each access cycle. At that edge `rd_data` takes `bus_rdata` for a read to a mapped region, and zero for a write or for an unmapped address. Otherwise `rd_data` holds its value.
- R9: `bus_enable` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_req | input | 1 | Transfer request from the client |
| cmd_addr | input | AW | Requested address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DW | Write data |
| cmd_ack | output | 1 | Request accepted at this edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Read result, valid with `done` |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | DW | Bus write data |
| bus_sel | output | NSEL | One-hot peripheral selects |
| bus_enable | output | 1 | Access-phase strobe |
| bus_rdata | input | DW | Read data from the selected slave |

## Verification
A wrong phase state shows up within one cycle, as an acknowledge given in setup or as an enable strobe missing, doubled or out of place. A wrong capture shows on `bus_addr` or `bus_sel` in the very cycle after acceptance, and a stale or unmasked read shows on `rd_data` together with the `done` pulse one cycle after the access cycle. The bench sends mixed traffic through every region and through unmapped space: reads, writes, back-to-back pairs to the same region and to different regions, and requests held across setup. It compares all outputs with a behavioural model on every cycle, so a fault shows at the first cycle it affects.

// File: rtl/pbus_seq_pkg.sv
package pbus_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;
endpackage

// File: rtl/pbus_region_decode.sv
module pbus_region_decode #(
  parameter int AW      = 16,
  parameter int NSEL    = 4,
  parameter int SEL_LSB = 12
) (
  input  logic [AW-1:0]   addr,
  output logic [NSEL-1:0] sel
);
  localparam int IDXW = (NSEL > 1) ? $clog2(NSEL) : 1;
  localparam int HIW  = AW - SEL_LSB - IDXW;

  logic [IDXW-1:0] idx;
  logic            in_map;

  assign idx    = addr[SEL_LSB +: IDXW];
  assign in_map = (addr[AW-1 -: HIW] == '0);

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = in_map && (idx == IDXW'(g));
  end
endmodule

// File: rtl/pbus_phase_fsm.sv
module pbus_phase_fsm
  import pbus_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic ack,
  output logic in_setup,
  output logic in_access
);
  phase_t ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE:   ph_q <= req ? PH_SETUP : PH_IDLE;
        PH_SETUP:  ph_q <= PH_ACCESS;
        PH_ACCESS: ph_q <= req ? PH_SETUP : PH_IDLE;
        default:   ph_q <= PH_IDLE;
      endcase
    end
  end

  assign in_setup  = (ph_q == PH_SETUP);
  assign in_access = (ph_q == PH_ACCESS);
  assign ack       = !rst && req && !in_setup;
endmodule

// File: rtl/pbus_xfer_regs.sv
module pbus_xfer_regs #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NSEL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            in_setup,
  input  logic            in_access,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            cmd_write,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [NSEL-1:0] dec_sel,
  input  logic [DW-1:0]   bus_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_write,
  output logic [DW-1:0]   bus_wdata,
  output logic [NSEL-1:0] bus_sel,
  output logic            bus_enable,
  output logic            done,
  output logic [DW-1:0]   rd_data
);
  logic read_hit;
  assign read_hit = !bus_write && (|bus_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr   <= '0;
      bus_write  <= 1'b0;
      bus_wdata  <= '0;
      bus_sel    <= '0;
      bus_enable <= 1'b0;
      done       <= 1'b0;
      rd_data    <= '0;
    end else begin
      bus_enable <= in_setup;
      done       <= in_access;
      if (in_access) begin
        rd_data <= read_hit ? bus_rdata : '0;
      end
      if (load) begin
        bus_addr  <= cmd_addr;
        bus_write <= cmd_write;
        bus_wdata <= cmd_wdata;
        bus_sel   <= dec_sel;
      end else if (in_access) begin
        bus_sel <= '0;
      end
    end
  end
endmodule

// File: rtl/pbus_master_seq.sv
module pbus_master_seq #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int NSEL    = 4,
  parameter int SEL_LSB = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_req,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            cmd_write,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            cmd_ack,
  output logic            done,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_write,
  output logic [DW-1:0]   bus_wdata,
  output logic [NSEL-1:0] bus_sel,
  output logic            bus_enable,
  input  logic [DW-1:0]   bus_rdata
);
  logic            in_setup;
  logic            in_access;
  logic [NSEL-1:0] dec_sel;

  pbus_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (cmd_req),
    .ack       (cmd_ack),
    .in_setup  (in_setup),
    .in_access (in_access)
  );

  pbus_region_decode #(.AW(AW), .NSEL(NSEL), .SEL_LSB(SEL_LSB)) u_dec (
    .addr (cmd_addr),
    .sel  (dec_sel)
  );

  pbus_xfer_regs #(.AW(AW), .DW(DW), .NSEL(NSEL)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .load       (cmd_ack),
    .in_setup   (in_setup),
    .in_access  (in_access),
    .cmd_addr   (cmd_addr),
    .cmd_write  (cmd_write),
    .cmd_wdata  (cmd_wdata),
    .dec_sel    (dec_sel),
    .bus_rdata  (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .done       (done),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/pbus_master_seq_chk.sv
module pbus_master_seq_chk #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NSEL = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_req,
  input logic [AW-1:0]   cmd_addr,
  input logic            cmd_write,
  input logic            cmd_ack,
  input logic            done,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_write,
  input logic [DW-1:0]   bus_wdata,
  input logic [NSEL-1:0] bus_sel,
  input logic            bus_enable
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (bus_sel == '0 && !bus_enable && !done && bus_addr == '0 && !bus_write));

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |-> cmd_req);

  assert_no_ack_in_setup_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> !cmd_ack);

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> (bus_addr == $past(cmd_addr) && bus_write == $past(cmd_write) && !bus_enable));

  assert_setup_then_access_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> !bus_enable ##1 bus_enable);

  assert_access_stable_R4: assert property (@(posedge clk) disable iff (rst)
    bus_enable |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata) && $stable(bus_sel)));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ack && !bus_enable) |=> ($stable(bus_addr) && $stable(bus_write)));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_sel));

  assert_done_follows_access_R8: assert property (@(posedge clk) disable iff (rst)
    bus_enable |=> done);

  assert_done_only_after_access_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_enable |=> !done);

  assert_enable_single_R9: assert property (@(posedge clk) disable iff (rst)
    bus_enable |=> !bus_enable);
endmodule

bind pbus_master_seq pbus_master_seq_chk #(.AW(AW), .DW(DW), .NSEL(NSEL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_req    (cmd_req),
  .cmd_addr   (cmd_addr),
  .cmd_write  (cmd_write),
  .cmd_ack    (cmd_ack),
  .done       (done),
  .bus_addr   (bus_addr),
  .bus_write  (bus_write),
  .bus_wdata  (bus_wdata),
  .bus_sel    (bus_sel),
  .bus_enable (bus_enable)
);

// File: tb/pbus_master_seq_tb.sv
`timescale 1ns/1ps
module pbus_master_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wd_i = '0;
  logic        cmd_ack, done, bus_write, bus_enable;
  logic [31:0] rd_data, bus_wdata, bus_rdata;
  logic [15:0] bus_addr;
  logic [3:0]  bus_sel;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // bench-side slave: data is a function of the address on the bus
  function automatic logic [31:0] slave_data(input logic [15:0] a);
    return {a ^ 16'hC35A, ~a};
  endfunction
  assign bus_rdata = slave_data(bus_addr);

  pbus_master_seq u_dut (
    .clk(clk), .rst(rst), .cmd_req(req_i), .cmd_addr(addr_i), .cmd_write(wr_i),
    .cmd_wdata(wd_i), .cmd_ack(cmd_ack), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_rdata(bus_rdata)
  );

  function automatic logic [3:0] region(input logic [15:0] a);
    if (a[15:14] != 2'b00) return 4'b0000;
    return 4'b0001 << a[13:12];
  endfunction

  // behavioural reference model: 0 idle, 1 setup, 2 access
  int          m_st = 0;
  logic [15:0] m_addr = '0;
  logic        m_wr = 1'b0;
  logic [31:0] m_wd = '0;
  logic [3:0]  m_sel = '0;
  logic        m_en = 1'b0;
  logic        m_done = 1'b0;
  logic [31:0] m_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_addr = '0; m_wr = 0; m_wd = '0; m_sel = '0;
      m_en = 0; m_done = 0; m_rd = '0;
    end else if (m_st == 1) begin
      m_st = 2; m_en = 1; m_done = 0;
    end else begin
      m_done = (m_st == 2);
      if (m_st == 2) m_rd = (!m_wr && m_sel != 0) ? slave_data(m_addr) : 32'h0;
      m_en = 0;
      if (req_i) begin
        m_addr = addr_i; m_wr = wr_i; m_wd = wd_i; m_sel = region(addr_i); m_st = 1;
      end else begin
        if (m_st == 2) m_sel = '0;
        m_st = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic prev_en = 1'b0;

  task automatic check_regs();
    chk(rst ? "R1 bus_sel" : "R7 bus_sel", 64'(bus_sel), 64'(m_sel));
    chk(rst ? "R1 bus_enable" : "R4 bus_enable", 64'(bus_enable), 64'(m_en));
    chk(rst ? "R1 bus_addr" : "R3 bus_addr", 64'(bus_addr), 64'(m_addr));
    chk("R3 bus_write", 64'(bus_write), 64'(m_wr));
    chk("R3 bus_wdata", 64'(bus_wdata), 64'(m_wd));
    chk("R8 done", 64'(done), 64'(m_done));
    chk("R8 rd_data", 64'(rd_data), 64'(m_rd));
    chk("R9 enable not repeated", 64'(prev_en && bus_enable), 64'(0));
    prev_en = bus_enable;
  endtask

  task automatic cycle(input logic r, input logic [15:0] a, input logic w,
                       input logic [31:0] d, output logic acked);
    @(negedge clk);
    check_regs();
    req_i = r; addr_i = a; wr_i = w; wd_i = d;
    #1;
    chk("R2 cmd_ack", 64'(cmd_ack), 64'(r && !rst && m_st != 1));
    acked = cmd_ack;
  endtask

  task automatic xfer(input logic [15:0] a, input logic w, input logic [31:0] d);
    logic acked;
    acked = 1'b0;
    while (!acked) cycle(1'b1, a, w, d, acked);
  endtask

  task automatic idle(input int n);
    logic acked;
    for (int i = 0; i < n; i++) cycle(1'b0, addr_i, wr_i, wd_i, acked);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [15:0] ra;
    // R1: reset state, with a request held to show no acknowledge
    req_i = 1'b1; addr_i = 16'h1234;
    repeat (3) begin
      @(negedge clk);
      check_regs();
      chk("R1 no ack in reset", 64'(cmd_ack), 64'(0));
    end
    req_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // single write, single read, unmapped read
    xfer(16'h1010, 1'b1, 32'hDEADBEEF); idle(4);
    xfer(16'h2044, 1'b0, 32'h0);        idle(4);
    xfer(16'h8044, 1'b0, 32'h0);        idle(4);
    chk("R7 unmapped read gives zero", 64'(rd_data), 64'(0));
    // R5: idle keeps address and write flag, selects low
    chk("R5 address held", 64'(bus_addr), 64'(16'h8044));
    chk("R5 selects low in idle", 64'(bus_sel), 64'(0));

    // R6: back-to-back to the same region, select kept high
    xfer(16'h3000, 1'b0, 32'h0);
    xfer(16'h3004, 1'b1, 32'h55AA55AA);
    @(negedge clk);
    check_regs();
    chk("R6 select kept high", 64'(bus_sel), 64'(4'b1000));
    chk("R6 enable low in new setup", 64'(bus_enable), 64'(0));
    idle(4);

    // back-to-back to different regions, and a long chain
    for (int k = 0; k < 8; k++) xfer(16'(k * 16'h1000 + k), k[0], 32'(k * 32'h01010101));
    idle(4);

    // pseudo-random mix
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr[15:0];
      if (lfsr[19:18] == 2'b00) idle(int'(lfsr[22:20]) + 1);
      else xfer(ra, lfsr[23], lfsr ^ 32'h13579BDF);
    end
    idle(4);

    // reset mid-transfer returns to the cleared state
    xfer(16'h0100, 1'b0, 32'h0);
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    chk("R1 reset mid-transfer", 64'({bus_sel, bus_enable, done}), 64'(0));
    rst = 1'b0;
    idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule